// File: doc/BRIEF.md
# Clock-loss monitor with internal-oscillator fallback

The block watches the peripheral clock derived from an external system clock source and decides, from a slow and independent internal RC clock, whether that clock is still running. A sticky activity flop is set by every edge of the monitored clock and is cleared once per sampling window. The window is the RC clock divided by a parameter, 64 by default, which gives a window of about 2 ms at 31 kHz. If the flop is found still clear at the end of a window, the monitored clock is declared lost.

On a loss the block raises a failure flag for software and requests a forced switch to the internal oscillator block. It selects the slow RC tap when the frequency tap field is zero and the faster internal oscillator otherwise. It also emits a one-cycle watchdog-clear pulse and a one-cycle clear for the running flag of whichever source had failed. The monitor stays disarmed while a start-up or wake sequence is in progress and while neither the primary nor the secondary source is reported as running. A primary that never comes up therefore raises no failure. A newly armed monitor evaluates only after one complete window.

All control and status logic runs on the RC clock. The enable and tap inputs are configuration and are treated as quasi-static. The flag-clear input is synchronous to the RC clock.

Top module: `clkfail_monitor`

## Requirements
- R1: While reset is asserted and directly after its release, every output is 0.
- R2: With the monitor armed and the monitored clock toggling, no failure pulse is produced over any number of windows.
- R3: When the monitored clock stops while the monitor is armed, a one-cycle watchdog-clear pulse appears at least SAMPLE_DIV-4 and at most 2*SAMPLE_DIV+8 RC cycles later. From the following cycle on, fail_flag and force_int are both 1.
- R4: The watchdog-clear pulse is accompanied in the same cycle by pri_clr when the primary was reported running, and otherwise by sec_clr. pri_clr and sec_clr are never 1 together, and each pulse lasts exactly one RC cycle.
- R5: While force_int is 1, fb_fast is 1 when tap is not 3'b000 and fb_slow is 1 when tap equals 3'b000. Both are 0 while force_int is 0, and they are never 1 together.
- R6: No failure is reported while pri_run and sec_run are both 0, while mon_en is 0, or while boot_hold is 1. This holds even when the monitored clock is stopped.
- R7: With only sec_run set, loss of the monitored clock is reported, and the failure is attributed to the secondary source.
- R8: fail_flag stays 1 until a one-cycle flag_clr pulse clears it. A failure in the same cycle as the clear wins.
- R9: force_int stays 1 until boot_hold is asserted. While force_int is 1 the monitor is disarmed and produces no further failure pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC clock (about 31 kHz), clocks all control logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mon_clk | input | 1 | Monitored peripheral clock (system clock divided by 4) |
| mon_en | input | 1 | Monitor enable (configuration) |
| pri_run | input | 1 | Primary source is providing the system clock |
| sec_run | input | 1 | Secondary source is providing the system clock |
| boot_hold | input | 1 | Start-up or wake sequence in progress; disarms and releases the fallback |
| tap | input | TAP_W | Internal oscillator frequency tap; zero selects the slow RC |
| flag_clr | input | 1 | Software clear of fail_flag, one RC cycle |
| fail_flag | output | 1 | Sticky failure interrupt flag |
| force_int | output | 1 | Request to clock the system from the internal oscillator block |
| fb_fast | output | 1 | Fallback to the fast internal oscillator |
| fb_slow | output | 1 | Fallback to the slow RC clock |
| wdt_clr | output | 1 | One-cycle watchdog clear at detection |
| pri_clr | output | 1 | One-cycle clear of the primary-running flag |
| sec_clr | output | 1 | One-cycle clear of the secondary-running flag |

## Verification
Every cycle, the assertions check the pulse discipline: the source clears are exclusive and come only with a watchdog clear, the watchdog clear lasts a single cycle, and a pulse leaves the flag and the fallback request set. They also check that the fallback selects are mutually exclusive, that a disarmed monitor raises nothing, that the sticky outputs hold, and that a window clear follows each sample tick. Only the bench scenarios can show the detection latency after the monitored clock stops, the absence of false failures while it runs at several rates, and the correct attribution to primary or secondary. They also cover the tap-dependent fallback choice and the start-up gating cases in which the primary never comes up.

// File: rtl/clkfail_pkg.sv
`timescale 1ns/1ps
package clkfail_pkg;
  localparam int unsigned SAMPLE_DIV_DEF = 64;
  localparam int unsigned SYNC_STAGES    = 2;
  localparam int unsigned TAP_W_DEF      = 3;

  typedef enum logic [1:0] {
    FS_NONE = 2'd0,
    FS_PRI  = 2'd1,
    FS_SEC  = 2'd2
  } fail_src_e;

  // Primary has priority when both running indications are present.
  function automatic fail_src_e pick_src(input logic pri, input logic sec);
    if (pri)      return FS_PRI;
    else if (sec) return FS_SEC;
    else          return FS_NONE;
  endfunction
endpackage

// File: rtl/clkfail_sync.sv
`timescale 1ns/1ps
module clkfail_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/clkfail_window.sv
`timescale 1ns/1ps
module clkfail_window #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic clr
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clr_q, clr_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    clr_d = tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clr_q <= clr_d;
    end
  end

  assign clr = clr_q;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
  AST_CLR_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> clr); // R3
endmodule

// File: rtl/clkfail_activity.sv
`timescale 1ns/1ps
module clkfail_activity #(
  parameter int unsigned STAGES = 2
) (
  input  logic mon_clk,
  input  logic rc_clk,
  input  logic rst_n,
  input  logic clr,
  output logic seen_s
);
  logic seen_q;
  logic act_rst_n;

  // Sample-side clear acts asynchronously on the monitored-clock flop,
  // so a dead monitored clock cannot block it.
  assign act_rst_n = rst_n & ~clr;

  always_ff @(posedge mon_clk or negedge act_rst_n) begin
    if (!act_rst_n) seen_q <= 1'b0;
    else            seen_q <= 1'b1;
  end

  clkfail_sync #(.W(1), .STAGES(STAGES)) u_seen_sync (
    .clk   (rc_clk),
    .rst_n (rst_n),
    .d     (seen_q),
    .q     (seen_s)
  );
endmodule

// File: rtl/clkfail_ctrl.sv
`timescale 1ns/1ps
module clkfail_ctrl
  import clkfail_pkg::*;
#(
  parameter int unsigned TAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             seen_s,
  input  logic             mon_en,
  input  logic             pri_s,
  input  logic             sec_s,
  input  logic             hold_s,
  input  logic             flag_clr,
  input  logic [TAP_W-1:0] tap,
  output logic             fail_flag,
  output logic             force_int,
  output logic             fb_fast,
  output logic             fb_slow,
  output logic             wdt_clr,
  output logic             pri_clr,
  output logic             sec_clr
);
  logic      armed, fail_now;
  logic      win_ok_q, win_ok_d;
  logic      flag_q, flag_d;
  logic      force_q, force_d;
  logic      wdt_q, wdt_d;
  fail_src_e src_q, src_d;

  always_comb begin
    armed    = mon_en & ~hold_s & (pri_s | sec_s) & ~force_q;
    // A freshly armed monitor waits one complete window before judging.
    fail_now = tick & armed & win_ok_q & ~seen_s;
    win_ok_d = armed ? (win_ok_q | tick) : 1'b0;
    flag_d   = fail_now | (flag_q & ~flag_clr);
    force_d  = fail_now | (force_q & ~hold_s);
    wdt_d    = fail_now;
    src_d    = fail_now ? pick_src(pri_s, sec_s) : FS_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_ok_q <= 1'b0;
      flag_q   <= 1'b0;
      force_q  <= 1'b0;
      wdt_q    <= 1'b0;
      src_q    <= FS_NONE;
    end else begin
      win_ok_q <= win_ok_d;
      flag_q   <= flag_d;
      force_q  <= force_d;
      wdt_q    <= wdt_d;
      src_q    <= src_d;
    end
  end

  assign fail_flag = flag_q;
  assign force_int = force_q;
  assign wdt_clr   = wdt_q;
  assign pri_clr   = (src_q == FS_PRI);
  assign sec_clr   = (src_q == FS_SEC);
  assign fb_fast   = force_q & (tap != '0);
  assign fb_slow   = force_q & (tap == '0);

  AST_SRC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_clr && sec_clr)); // R4
  AST_SRC_WITH_WDT: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_clr || sec_clr) |-> wdt_clr); // R4
  AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_clr); // R4
  AST_FAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> (fail_flag && force_int)); // R3
  AST_FB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fb_fast, fb_slow})); // R5
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !wdt_clr); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !flag_clr) |=> fail_flag); // R8
  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (force_int && !hold_s) |=> force_int); // R9
endmodule

// File: rtl/clkfail_monitor.sv
`timescale 1ns/1ps
module clkfail_monitor
  import clkfail_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = SAMPLE_DIV_DEF,
  parameter int unsigned TAP_W      = TAP_W_DEF
) (
  input  logic             rc_clk,
  input  logic             rst_n,
  input  logic             mon_clk,
  input  logic             mon_en,
  input  logic             pri_run,
  input  logic             sec_run,
  input  logic             boot_hold,
  input  logic [TAP_W-1:0] tap,
  input  logic             flag_clr,
  output logic             fail_flag,
  output logic             force_int,
  output logic             fb_fast,
  output logic             fb_slow,
  output logic             wdt_clr,
  output logic             pri_clr,
  output logic             sec_clr
);
  localparam int unsigned NSTAT = 3;

  logic [1:0]       rst_q, rst_d;
  logic             rst_rc_n;
  logic             tick, win_clr, seen_s;
  logic [NSTAT-1:0] stat_s;

  // Reset: asserted asynchronously, released on the RC clock.
  always_comb rst_d = {rst_q[0], 1'b1};

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= rst_d;
  end

  assign rst_rc_n = rst_q[1];

  clkfail_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_stat_sync (
    .clk   (rc_clk),
    .rst_n (rst_rc_n),
    .d     ({boot_hold, sec_run, pri_run}),
    .q     (stat_s)
  );

  clkfail_window #(.DIV(SAMPLE_DIV)) u_window (
    .clk   (rc_clk),
    .rst_n (rst_rc_n),
    .tick  (tick),
    .clr   (win_clr)
  );

  clkfail_activity #(.STAGES(SYNC_STAGES)) u_activity (
    .mon_clk (mon_clk),
    .rc_clk  (rc_clk),
    .rst_n   (rst_rc_n),
    .clr     (win_clr),
    .seen_s  (seen_s)
  );

  clkfail_ctrl #(.TAP_W(TAP_W)) u_ctrl (
    .clk       (rc_clk),
    .rst_n     (rst_rc_n),
    .tick      (tick),
    .seen_s    (seen_s),
    .mon_en    (mon_en),
    .pri_s     (stat_s[0]),
    .sec_s     (stat_s[1]),
    .hold_s    (stat_s[2]),
    .flag_clr  (flag_clr),
    .tap       (tap),
    .fail_flag (fail_flag),
    .force_int (force_int),
    .fb_fast   (fb_fast),
    .fb_slow   (fb_slow),
    .wdt_clr   (wdt_clr),
    .pri_clr   (pri_clr),
    .sec_clr   (sec_clr)
  );
endmodule

// File: tb/test_clkfail_monitor.sv
`timescale 1ns/1ps
module test_clkfail_monitor;
  localparam int RC_PERIOD = 20;
  localparam int DIV       = 64;
  localparam int TW        = 3;

  logic          rc_clk, rst_n, mon_clk;
  logic          mon_en, pri_run, sec_run, boot_hold, flag_clr;
  logic [TW-1:0] tap;
  logic          fail_flag, force_int, fb_fast, fb_slow, wdt_clr, pri_clr, sec_clr;
  logic          mon_run;
  int            mon_half;
  int            n_cmp = 0;
  int            n_bad = 0;

  clkfail_monitor #(.SAMPLE_DIV(DIV), .TAP_W(TW)) i_clkfail_monitor (
    .rc_clk(rc_clk), .rst_n(rst_n), .mon_clk(mon_clk), .mon_en(mon_en),
    .pri_run(pri_run), .sec_run(sec_run), .boot_hold(boot_hold), .tap(tap),
    .flag_clr(flag_clr), .fail_flag(fail_flag), .force_int(force_int),
    .fb_fast(fb_fast), .fb_slow(fb_slow), .wdt_clr(wdt_clr),
    .pri_clr(pri_clr), .sec_clr(sec_clr)
  );

  initial begin
    rc_clk = 0;
    forever #(RC_PERIOD/2) rc_clk = ~rc_clk;
  end

  initial begin
    mon_clk = 0;
    forever begin
      if (mon_run) #(mon_half) mon_clk = ~mon_clk;
      else begin mon_clk = 0; #1; end
    end
  end

  initial begin
    #(RC_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic bit ref_fast(input logic [TW-1:0] t); return t != 0; endfunction
  function automatic bit ref_pri(input bit p, input bit s); return p; endfunction
  function automatic bit ref_sec(input bit p, input bit s); return !p && s; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge rc_clk);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge rc_clk);
      if (wdt_clr) pulses++;
    end
    chk(pulses == 0, tag, pulses, 0);
  endtask

  task automatic expect_failure(input bit ep, input bit es, input int lo,
                                input logic [TW-1:0] t, input string tag);
    int lat = -1;
    bit p = 0, s = 0;
    for (int n = 0; n < 2*DIV + 8; n++) begin
      @(negedge rc_clk);
      if (wdt_clr) begin lat = n; p = pri_clr; s = sec_clr; break; end
    end
    chk(lat >= lo, {tag, " R3 latency"}, lat, lo);
    chk(p == ep, {tag, " R4 pri_clr"}, p, ep);
    chk(s == es, {tag, " R4 sec_clr"}, s, es);
    @(negedge rc_clk);
    chk(!wdt_clr && !pri_clr && !sec_clr, {tag, " R4 single pulse"}, wdt_clr, 0);
    chk(fail_flag && force_int, {tag, " R3 flags"}, {fail_flag, force_int}, 3);
    chk(fb_fast == ref_fast(t) && fb_slow == !ref_fast(t), {tag, " R5 fallback"},
        {fb_fast, fb_slow}, {ref_fast(t), !ref_fast(t)});
  endtask

  task automatic rearm(input bit p, input bit s);
    flag_clr = 1; @(negedge rc_clk); flag_clr = 0;
    boot_hold = 1; cycles(6);
    pri_run = p; sec_run = s; mon_run = 1;
    boot_hold = 0; cycles(4);
  endtask

  initial begin
    mon_run = 0; mon_half = 3;
    rst_n = 0; mon_en = 1; pri_run = 0; sec_run = 0; boot_hold = 0;
    flag_clr = 0; tap = 3'b011;
    cycles(3);
    chk({fail_flag, force_int, fb_fast, fb_slow, wdt_clr, pri_clr, sec_clr} == 0,
        "R1 in reset", {fail_flag, force_int, wdt_clr}, 0);
    rst_n = 1;
    cycles(4);
    chk({fail_flag, force_int, fb_fast, fb_slow, wdt_clr, pri_clr, sec_clr} == 0,
        "R1 after release", {fail_flag, force_int, wdt_clr}, 0);

    // Primary running, monitored clock toggling.
    pri_run = 1; mon_run = 1;
    expect_quiet(5*DIV, "R2 running clock");
    mon_run = 0;
    expect_failure(1, 0, DIV - 4, tap, "directed pri");

    // Held outputs and disarm after failure.
    expect_quiet(3*DIV, "R9 no repeat");
    chk(force_int == 1, "R9 force held", force_int, 1);
    chk(fail_flag == 1, "R8 flag held", fail_flag, 1);
    flag_clr = 1; @(negedge rc_clk); flag_clr = 0; @(negedge rc_clk);
    chk(fail_flag == 0, "R8 flag cleared", fail_flag, 0);
    chk(force_int == 1, "R9 force after flag clear", force_int, 1);
    boot_hold = 1; cycles(5);
    chk(force_int == 0 && fb_fast == 0 && fb_slow == 0, "R9 released by boot_hold",
        force_int, 0);

    // Start-up gating: nothing running, stopped clock.
    pri_run = 0; sec_run = 0; boot_hold = 0;
    expect_quiet(4*DIV, "R6 no source running");
    mon_en = 0; pri_run = 1;
    expect_quiet(4*DIV, "R6 disabled");
    mon_en = 1; boot_hold = 1;
    expect_quiet(4*DIV, "R6 boot hold");
    chk(fail_flag == 0, "R6 flag stays clear", fail_flag, 0);
    boot_hold = 0; tap = 3'b000;
    expect_failure(1, 0, 0, tap, "armed stopped");

    // Secondary only.
    rearm(0, 1);
    expect_quiet(3*DIV, "R2 secondary running");
    mon_run = 0;
    expect_failure(0, 1, DIV - 4, tap, "R7 secondary");

    // Clear and failure in the same cycle: failure wins.
    rearm(1, 0);
    expect_quiet(2*DIV, "R2 pre-race");
    mon_run = 0;
    begin
      int got = 0;
      for (int n = 0; n < 2*DIV + 8; n++) begin
        flag_clr = 1;
        @(negedge rc_clk);
        if (wdt_clr) begin got = 1; break; end
      end
      flag_clr = 0;
      @(negedge rc_clk);
      chk(got == 1 && fail_flag == 1, "R8 set wins over clear", fail_flag, 1);
    end

    // Constrained random rounds.
    begin
      int seed_dummy = $urandom(32'h5eed_1234);
      for (int it = 0; it < 8; it++) begin
        bit p, s;
        int sel = $urandom_range(0, 2);
        p = (sel != 1);
        s = (sel != 0);
        tap = TW'($urandom_range(0, 7));
        mon_half = $urandom_range(2, 5);
        rearm(p, s);
        expect_quiet($urandom_range(2, 4) * DIV, "R2 random run");
        cycles($urandom_range(0, DIV));
        mon_run = 0;
        expect_failure(ref_pri(p, s), ref_sec(p, s), DIV - 4, tap, "random");
      end
      if (seed_dummy < 0) $display("seed");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule